// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a four-bank DDR SDRAM. After reset it keeps the memory quiet, with the clock-enable pin low and a NOP on the command pins. It waits for a start request and then walks the device through its whole bring-up. First it waits a long power-stable interval and raises clock enable. It then closes all banks and turns the delay-locked loop on through the extended mode register. Next it writes the mode register with the loop-reset bit set and waits for the loop to lock. After that it closes all banks again, runs a burst of auto-refresh commands, and writes the operating mode register. A done flag then rises and stays high.

Every interval is a parameter counted in clock cycles. These are the power-stable wait, precharge time, refresh cycle time, mode-register set time and lock wait. The number of refresh commands is also a parameter. The operating mode word and the extended mode word are taken from input ports when the start request is accepted. Later changes on those ports have no effect on the run in progress.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is asserted, and in idle before a start request, `cke_o` is 0, `{cs_n_o,ras_n_o,cas_n_o,we_n_o}` is the NOP code 4'b0111, `ba_o` and `addr_o` are 0, and `init_done_o` is 0.
- R2: A start request sampled at a clock edge in idle begins the run. `cke_o` stays 0 for PWR_CYC cycles, then goes to 1 and stays 1 until reset.
- R3: Every cycle that carries no command drives NOP with `ba_o` and `addr_o` at 0. Exactly one NOP cycle with `cke_o` high comes before the first command.
- R4: Precharge-all is coded 4'b0010 with only `addr_o[10]` set and `ba_o` 0. It is issued twice: once right after the CKE-high NOP, and again LOCK_CYC cycles after the loop-reset mode write.
- R5: The loop-enable extended mode write is coded 4'b0000 with `ba_o` = 2'b01. `addr_o[0]` is 0 and `addr_o[11:1]` is taken from the captured extended word. It comes T_RP cycles after the first precharge-all.
- R6: The loop-reset mode write is coded 4'b0000 with `ba_o` = 2'b00. `addr_o[8]` is forced to 1 and the other bits come from the captured mode word. It comes T_MRD cycles after the extended mode write.
- R7: N_REF auto-refresh commands, coded 4'b0001, follow the second precharge-all. The first comes T_RP cycles after it, and each later one comes T_RFC cycles after the one before.
- R8: The final mode write is coded 4'b0000 with `ba_o` = 2'b00 and the captured mode word, but with `addr_o[8]` forced to 0. It comes T_RFC cycles after the last refresh.
- R9: `init_done_o` rises T_MRD cycles after the final mode write. It then stays high with only NOP on the command pins until reset.
- R10: Once a run has started, changes on `mode_val_i`, `ext_val_i` and `start_i` have no effect on the outputs.
- R11: Asserting reset in the middle of a run returns every output to the R1 state at once. A later start runs the full sequence again from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled in idle |
| mode_val_i | input | AW | Operating mode register word |
| ext_val_i | input | AW | Extended mode register word (bit 0 overridden) |
| cke_o | output | 1 | Clock enable to the memory |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | 2 | Bank address |
| addr_o | output | AW | Address bus |
| init_done_o | output | 1 | Initialization complete, sticky |

## Verification
The hardest situation to reach is a disturbance in the middle of the run. This means mode words that change and start pulses that arrive while the long waits are counting, and also a reset that arrives partway through. Each must leave every later command slot exactly on schedule, with the values captured at start. The bench gets there by drawing random words and random disturbance cycles from a seeded generator. It then replays a cycle-exact schedule computed from the parameters, and it aborts one run with reset during the lock wait before running a clean sequence again.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_PRE = 4'b0010,
    CMD_REF = 4'b0001,
    CMD_MRS = 4'b0000
  } cmd_e;

  typedef enum logic [2:0] {
    STP_PRE1,
    STP_EXT,
    STP_DLLRST,
    STP_PRE2,
    STP_REF,
    STP_FINAL
  } step_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PWR,
    PH_CKE,
    PH_ISSUE,
    PH_GAP,
    PH_DONE
  } phase_e;

  function automatic cmd_e step_cmd(step_e s);
    case (s)
      STP_PRE1, STP_PRE2: return CMD_PRE;
      STP_REF:            return CMD_REF;
      default:            return CMD_MRS;
    endcase
  endfunction

  // cycles from this step's command to the next command
  function automatic int unsigned step_gap(step_e s, int unsigned trp,
                                           int unsigned tmrd, int unsigned tlock,
                                           int unsigned trfc);
    case (s)
      STP_PRE1, STP_PRE2: return trp;
      STP_EXT, STP_FINAL: return tmrd;
      STP_DLLRST:         return tlock;
      default:            return trfc;
    endcase
  endfunction

  function automatic step_e step_after(step_e s);
    case (s)
      STP_PRE1:   return STP_EXT;
      STP_EXT:    return STP_DLLRST;
      STP_DLLRST: return STP_PRE2;
      STP_PRE2:   return STP_REF;
      default:    return STP_FINAL;
    endcase
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          zero_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R3: a running wait counts down by exactly one per cycle
  a_r3_timer_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !zero_o) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/ddr_init_fsm.sv
module ddr_init_fsm
  import ddr_init_pkg::*;
#(
  parameter int unsigned PWR_CYC  = 25000,
  parameter int unsigned T_RP     = 3,
  parameter int unsigned T_MRD    = 2,
  parameter int unsigned LOCK_CYC = 200,
  parameter int unsigned T_RFC    = 10,
  parameter int unsigned N_REF    = 2,
  parameter int          CW       = 16
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  output phase_e phase_o,
  output step_e  step_o,
  output logic   capture_o,
  output logic   cke_o,
  output logic   done_o
);

  localparam int RW = $clog2(N_REF + 1);

  phase_e        phase_q, phase_d;
  step_e         step_q, step_d;
  logic [RW-1:0] ref_q, ref_d;
  logic          tmr_load, tmr_zero;
  logic [CW-1:0] tmr_val;
  logic          gap_end;

  ddr_init_timer #(.CW(CW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  assign gap_end = (phase_q == PH_GAP) && tmr_zero;

  always_comb begin
    phase_d  = phase_q;
    step_d   = step_q;
    ref_d    = ref_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (phase_q)
      PH_IDLE: if (start_i) begin
        phase_d  = PH_PWR;
        tmr_load = 1'b1;
        tmr_val  = CW'(PWR_CYC - 1);
      end
      PH_PWR: if (tmr_zero) phase_d = PH_CKE;
      PH_CKE: begin
        phase_d = PH_ISSUE;
        step_d  = STP_PRE1;
        ref_d   = '0;
      end
      PH_ISSUE: begin
        phase_d  = PH_GAP;
        tmr_load = 1'b1;
        tmr_val  = CW'(step_gap(step_q, T_RP, T_MRD, LOCK_CYC, T_RFC) - 2);
      end
      PH_GAP: if (tmr_zero) begin
        if (step_q == STP_FINAL) begin
          phase_d = PH_DONE;
        end else if (step_q == STP_REF && ref_q != RW'(N_REF - 1)) begin
          phase_d = PH_ISSUE;
          ref_d   = ref_q + 1'b1;
        end else begin
          phase_d = PH_ISSUE;
          step_d  = step_after(step_q);
        end
      end
      default: phase_d = PH_DONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      step_q  <= STP_PRE1;
      ref_q   <= '0;
    end else begin
      phase_q <= phase_d;
      step_q  <= step_d;
      ref_q   <= ref_d;
    end
  end

  assign phase_o   = phase_q;
  assign step_o    = step_q;
  assign capture_o = (phase_q == PH_IDLE) && start_i;
  assign cke_o     = (phase_q != PH_IDLE) && (phase_q != PH_PWR);
  assign done_o    = (phase_q == PH_DONE);

  // R7: the refresh counter never passes the configured count
  a_r7_ref_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_q < RW'(N_REF)));

  // R9: the final gap ending is what leads to completion
  a_r9_done_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gap_end && step_q == STP_FINAL) |=> done_o);

endmodule

// File: rtl/ddr_init_cmd_enc.sv
module ddr_init_cmd_enc
  import ddr_init_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          capture_i,
  input  logic [AW-1:0] mode_i,
  input  logic [AW-1:0] ext_i,
  input  phase_e        phase_i,
  input  step_e         step_i,
  output logic [3:0]    cmd_o,
  output logic [1:0]    ba_o,
  output logic [AW-1:0] addr_o
);

  localparam int AP_BIT  = 10;
  localparam int DLL_BIT = 8;

  logic [AW-1:0] mode_q, ext_q;
  logic          fire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      ext_q  <= '0;
    end else if (capture_i) begin
      mode_q <= mode_i;
      ext_q  <= ext_i;
    end
  end

  assign fire = (phase_i == PH_ISSUE);

  always_comb begin
    cmd_o  = CMD_NOP;
    ba_o   = 2'b00;
    addr_o = '0;
    if (fire) begin
      cmd_o = step_cmd(step_i);
      case (step_i)
        STP_PRE1, STP_PRE2: addr_o[AP_BIT] = 1'b1;
        STP_EXT: begin
          ba_o   = 2'b01;
          addr_o = {ext_q[AW-1:1], 1'b0};
        end
        STP_DLLRST: begin
          addr_o          = mode_q;
          addr_o[DLL_BIT] = 1'b1;
        end
        STP_FINAL: begin
          addr_o          = mode_q;
          addr_o[DLL_BIT] = 1'b0;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int unsigned PWR_CYC  = 25000,
  parameter int unsigned T_RP     = 3,
  parameter int unsigned T_MRD    = 2,
  parameter int unsigned LOCK_CYC = 200,
  parameter int unsigned T_RFC    = 10,
  parameter int unsigned N_REF    = 2,
  parameter int          AW       = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] mode_val_i,
  input  logic [AW-1:0] ext_val_i,
  output logic          cke_o,
  output logic          cs_n_o,
  output logic          ras_n_o,
  output logic          cas_n_o,
  output logic          we_n_o,
  output logic [1:0]    ba_o,
  output logic [AW-1:0] addr_o,
  output logic          init_done_o
);

  localparam int unsigned MAXV = max2(max2(PWR_CYC, LOCK_CYC), max2(T_RFC, max2(T_RP, T_MRD)));
  localparam int CW = $clog2(MAXV + 1);

  phase_e     phase;
  step_e      step;
  logic       capture;
  logic [3:0] cmd;
  logic       cmd_busy;

  ddr_init_fsm #(
    .PWR_CYC(PWR_CYC), .T_RP(T_RP), .T_MRD(T_MRD), .LOCK_CYC(LOCK_CYC),
    .T_RFC(T_RFC), .N_REF(N_REF), .CW(CW)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .phase_o   (phase),
    .step_o    (step),
    .capture_o (capture),
    .cke_o     (cke_o),
    .done_o    (init_done_o)
  );

  ddr_init_cmd_enc #(.AW(AW)) u_enc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture),
    .mode_i    (mode_val_i),
    .ext_i     (ext_val_i),
    .phase_i   (phase),
    .step_i    (step),
    .cmd_o     (cmd),
    .ba_o      (ba_o),
    .addr_o    (addr_o)
  );

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd;
  assign cmd_busy = (cmd != CMD_NOP);

  // R2: clock enable never drops once raised
  a_r2_cke_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_o |=> cke_o);

  // R3: no command is driven while clock enable is low
  a_r3_cmd_needs_cke: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_busy |-> cke_o);

  // R9: done is sticky and quiet
  a_r9_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);
  a_r9_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |-> !cmd_busy);

  // R3: commands are single-cycle pulses
  a_r3_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_busy |=> !cmd_busy);

endmodule

// File: tb/ddr_init_seq_bench.sv
module ddr_init_seq_bench;

  localparam int PWR  = 40;
  localparam int TRP  = 3;
  localparam int TMRD = 2;
  localparam int LOCK = 200;
  localparam int TRFC = 9;
  localparam int NREF = 3;
  localparam int AW   = 12;

  localparam int T0 = PWR + 1;
  localparam int TE = T0 + TRP;
  localparam int TM = TE + TMRD;
  localparam int TP = TM + LOCK;
  localparam int TR = TP + TRP;
  localparam int TF = TR + NREF * TRFC;
  localparam int TD = TF + TMRD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] mode_v = '0, ext_v = '0;
  logic cke, cs_n, ras_n, cas_n, we_n, done;
  logic [1:0] ba;
  logic [AW-1:0] addr;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  ddr_init_seq #(
    .PWR_CYC(PWR), .T_RP(TRP), .T_MRD(TMRD), .LOCK_CYC(LOCK),
    .T_RFC(TRFC), .N_REF(NREF), .AW(AW)
  ) u_ddr_init_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .mode_val_i(mode_v), .ext_val_i(ext_v),
    .cke_o(cke), .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
    .ba_o(ba), .addr_o(addr), .init_done_o(done)
  );

  // {done, cke, cmd[3:0], ba[1:0], addr}
  function automatic logic [AW+7:0] expect_at(int k, logic [AW-1:0] m, logic [AW-1:0] e);
    logic [3:0] c; logic [1:0] b; logic [AW-1:0] a; logic dn, ck;
    c = 4'b0111; b = 2'b00; a = '0;
    ck = (k >= PWR);
    dn = (k >= TD);
    if (k == T0 || k == TP) begin c = 4'b0010; a = 12'h400; end
    else if (k == TE) begin c = 4'b0000; b = 2'b01; a = {e[AW-1:1], 1'b0}; end
    else if (k == TM) begin c = 4'b0000; a = m | 12'h100; end
    else if (k >= TR && k < TF && ((k - TR) % TRFC) == 0) c = 4'b0001;
    else if (k == TF) begin c = 4'b0000; a = m & ~12'h100; end
    return {dn, ck, c, b, a};
  endfunction

  function automatic string req_at(int k);
    if (k < PWR) return "R2";
    if (k == PWR) return "R3";
    if (k == T0 || k == TP) return "R4";
    if (k == TE) return "R5";
    if (k == TM) return "R6";
    if (k >= TR && k < TF) return "R7";
    if (k == TF) return "R8";
    if (k >= TD) return "R9";
    return "R3";
  endfunction

  task automatic check(string req, logic [AW+7:0] exp_v);
    logic [AW+7:0] act;
    act = {done, cke, cs_n, ras_n, cas_n, we_n, ba, addr};
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s t=%0t actual=%h expected=%h", req, $time, act, exp_v);
    end
  endtask

  // R1 idle pattern: NOP, cke low, all address zero, not done
  task automatic check_idle(string req);
    check(req, {1'b0, 1'b0, 4'b0111, 2'b00, {AW{1'b0}}});
  endtask

  // drive one run; disturb applies R10 stimulus; stop_at < 0 means full run
  task automatic run(logic [AW-1:0] m, logic [AW-1:0] e, bit disturb, int stop_at);
    int d1, d2;
    d1 = 2 + int'($urandom_range(PWR - 4));
    d2 = TE + 1 + int'($urandom_range(LOCK - 10));
    @(negedge clk);
    start = 1'b1; mode_v = m; ext_v = e;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < TD + 6; k++) begin
      if (stop_at >= 0 && k == stop_at) return;
      if (disturb && (k == d1 || k == d2 || k == TD + 2)) begin
        mode_v = 12'(~m); ext_v = 12'($urandom); start = 1'b1;
      end else begin
        start = 1'b0;
      end
      check(disturb ? "R10" : req_at(k), expect_at(k, m, e));
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d2c_3b4a));
    // R1: in reset
    @(negedge clk); check_idle("R1");
    @(negedge clk); check_idle("R1");
    rst_n = 1'b1;
    // R1: idle without start
    repeat (4) begin @(negedge clk); check_idle("R1"); end
    // directed corner: all-ones words, then all-zero words
    run(12'hFFF, 12'hFFF, 1'b0, -1);
    rst_n = 1'b0; @(negedge clk); check_idle("R1"); rst_n = 1'b1;
    run(12'h000, 12'h000, 1'b0, -1);
    // random words with R10 disturbance
    for (int i = 0; i < 3; i++) begin
      rst_n = 1'b0; @(negedge clk); check_idle("R1"); rst_n = 1'b1;
      run(12'($urandom), 12'($urandom), 1'b1, -1);
    end
    // R11: reset in the middle of the lock wait
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    run(12'h0A5, 12'h002, 1'b0, TM + 50);
    #1 rst_n = 1'b0;
    #1 check_idle("R11");
    @(negedge clk); check_idle("R11");
    rst_n = 1'b1;
    repeat (3) begin @(negedge clk); check_idle("R11"); end
    run(12'($urandom), 12'($urandom), 1'b0, -1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule